// File: doc/BRIEF.md
# Flag Offset Register Loader

This block keeps the four threshold offsets that a pair of FIFOs uses to raise their almost-empty and almost-full flags. There is one empty-side offset and one full-side offset per FIFO, called X and Y. Each offset is as wide as the address of a FIFO of depth `DEPTH`, which gives 10 bits at the default depth of 1024. The FIFO memories and the flag comparators sit outside this block. They read the four offset outputs and the `prog_done` indication.

The loading method is chosen while master reset is held low. The two select pins also carry the preset choice during reset. After reset the same two pins become the serial enable (active low) and the serial data. Three methods exist:

- **Preset.** All four offsets take one fixed value, which is 8, 16 or 64.
- **Parallel.** Words on `par_data` are written into the offsets one at a time, each on a `par_wr` strobe.
- **Serial.** A 40-bit stream is shifted in on the port A clock.

Every register, the reset included, is synchronous to `clk`.

Top module: `flag_offset_loader`

## Requirements
- R1: While `rst_n` is low, every clock edge captures the method and clears the bit/word counter. Serial and parallel methods then show all offsets 0 with `prog_done` low. The preset method shows the preset on all four offsets with `prog_done` high.
- R2: The method is chosen from `prog_mode` and the select pair `{sel1_sen_n, sel0_sdata}`. `prog_mode`=0 selects serial. `prog_mode`=1 with pair 2'b00 selects parallel. With `prog_mode`=1, pair 2'b01 gives preset 8, 2'b10 gives 16 and 2'b11 gives 64, on all four offsets.
- R3: The method and preset in force are the ones sampled on the last clock edge with `rst_n` low. Later activity on the shared pins does not change them.
- R4: In serial mode, each clock edge with `sel1_sen_n` low shifts in the bit on `sel0_sdata`. An edge with `sel1_sen_n` high leaves the offsets unchanged.
- R5: Serial bits fill the offsets MSB first, in the order Y1, X1, Y2, X2. The first bit is the MSB of `ofs_y1` and bit 40 is the LSB of `ofs_x2`. Part way through the stream, the bits taken so far sit right-aligned in the concatenation {Y1,X1,Y2,X2}.
- R6: After 40 bits are accepted, further serial bits are ignored. `prog_done` is high from the clock edge that takes bit 40.
- R7: In parallel mode, each `par_wr` edge stores `par_data` into the next offset, in the order Y1, X1, Y2, X2. `prog_done` rises with the fourth write, and later writes are ignored.
- R8: In serial mode `par_wr` has no effect. In parallel mode the serial enable has no effect. In preset mode neither has any effect.
- R9: Once `prog_done` is high, it and all four offsets stay constant until `rst_n` goes low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port A clock |
| rst_n | input | 1 | Master reset, active low, synchronous; the method is sampled while it is low |
| prog_mode | input | 1 | 0 = serial load, 1 = parallel load or preset |
| sel1_sen_n | input | 1 | Preset select bit 1 during reset; serial enable (active low) afterwards |
| sel0_sdata | input | 1 | Preset select bit 0 during reset; serial data afterwards |
| par_wr | input | 1 | Parallel write strobe |
| par_data | input | $clog2(DEPTH) | Parallel offset word |
| ofs_x1 | output | $clog2(DEPTH) | Empty-side offset, FIFO 1 |
| ofs_y1 | output | $clog2(DEPTH) | Full-side offset, FIFO 1 |
| ofs_x2 | output | $clog2(DEPTH) | Empty-side offset, FIFO 2 |
| ofs_y2 | output | $clog2(DEPTH) | Full-side offset, FIFO 2 |
| prog_done | output | 1 | Offsets fully programmed |

## Verification
The properties assume that every input holds a known level on each edge while `rst_n` is low. The state is rebuilt only from those pins, so the properties are disabled during reset and compare the state with `$past` values only after release. The bench meets this by driving all pins from time zero and holding reset for several edges. In some runs the pins change on the final reset edge, which exercises the capture rule. All inputs change on the falling clock edge. The shared pins are toggled freely after reset, because the design has to ignore them outside serial mode.

// File: rtl/fofs_pkg.sv
package fofs_pkg;

    // Loading method latched during master reset
    typedef enum logic [1:0] {
        MODE_SERIAL   = 2'd0,
        MODE_PARALLEL = 2'd1,
        MODE_PRESET   = 2'd2
    } fofs_mode_e;

    // Number of offset registers: Y1, X1, Y2, X2 (load order)
    localparam int unsigned FOFS_SLOTS = 4;

endpackage

// File: rtl/fofs_cfg_decode.sv
module fofs_cfg_decode
    import fofs_pkg::*;
#(
    parameter int unsigned OFS_W = 10
) (
    input  logic             mode_pin,
    input  logic [1:0]       sel,
    output fofs_mode_e       mode,
    output logic [OFS_W-1:0] preset
);

    always_comb begin
        case (sel)
            2'b01:   preset = OFS_W'(8);
            2'b10:   preset = OFS_W'(16);
            2'b11:   preset = OFS_W'(64);
            default: preset = '0;
        endcase

        if (!mode_pin) begin
            mode = MODE_SERIAL;
        end else if (sel == 2'b00) begin
            mode = MODE_PARALLEL;
        end else begin
            mode = MODE_PRESET;
        end
    end

endmodule

// File: rtl/fofs_serial_step.sv
module fofs_serial_step #(
    parameter int unsigned IMG_W = 40,
    parameter int unsigned CNT_W = 6
) (
    input  logic [IMG_W-1:0] img,
    input  logic [CNT_W-1:0] cnt,
    input  logic             en,
    input  logic             bit_in,
    output logic [IMG_W-1:0] img_nx,
    output logic [CNT_W-1:0] cnt_nx
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(IMG_W);

    logic full;

    always_comb begin
        full   = (cnt == LAST_CNT);
        img_nx = img;
        cnt_nx = cnt;
        if (en && !full) begin
            img_nx = {img[IMG_W-2:0], bit_in};
            cnt_nx = cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fofs_par_step.sv
module fofs_par_step #(
    parameter int unsigned OFS_W = 10,
    parameter int unsigned SLOTS = 4,
    parameter int unsigned CNT_W = 6
) (
    input  logic [OFS_W*SLOTS-1:0] img,
    input  logic [CNT_W-1:0]       cnt,
    input  logic                   wr,
    input  logic [OFS_W-1:0]       data,
    output logic [OFS_W*SLOTS-1:0] img_nx,
    output logic [CNT_W-1:0]       cnt_nx
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SLOTS);

    logic take;

    assign take   = wr && (cnt != LAST_CNT);
    assign cnt_nx = take ? cnt + 1'b1 : cnt;

    // Slot s (0 = first written) lives at the top of the image
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam int unsigned LSB = (SLOTS - 1 - s) * OFS_W;
        assign img_nx[LSB +: OFS_W] = (take && cnt == CNT_W'(s)) ? data : img[LSB +: OFS_W];
    end

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
    import fofs_pkg::*;
#(
    parameter int unsigned DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prog_mode,
    input  logic                     sel1_sen_n,
    input  logic                     sel0_sdata,
    input  logic                     par_wr,
    input  logic [$clog2(DEPTH)-1:0] par_data,
    output logic [$clog2(DEPTH)-1:0] ofs_x1,
    output logic [$clog2(DEPTH)-1:0] ofs_y1,
    output logic [$clog2(DEPTH)-1:0] ofs_x2,
    output logic [$clog2(DEPTH)-1:0] ofs_y2,
    output logic                     prog_done
);

    localparam int unsigned OFS_W = $clog2(DEPTH);
    localparam int unsigned SLOTS = FOFS_SLOTS;
    localparam int unsigned IMG_W = OFS_W * SLOTS;
    localparam int unsigned CNT_W = $clog2(IMG_W + 1);
    localparam logic [CNT_W-1:0] SER_END = CNT_W'(IMG_W);
    localparam logic [CNT_W-1:0] PAR_END = CNT_W'(SLOTS);

    typedef struct packed {
        fofs_mode_e       mode;
        logic [IMG_W-1:0] img;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } state_t;

    state_t st_d, st_q;

    fofs_mode_e       cfg_mode;
    logic [OFS_W-1:0] cfg_preset;
    logic [IMG_W-1:0] ser_img_nx, par_img_nx;
    logic [CNT_W-1:0] ser_cnt_nx, par_cnt_nx;
    logic             ser_en, par_en;

    assign ser_en = (st_q.mode == MODE_SERIAL) && !sel1_sen_n;
    assign par_en = (st_q.mode == MODE_PARALLEL) && par_wr;

    fofs_cfg_decode #(.OFS_W(OFS_W)) i_cfg (
        .mode_pin (prog_mode),
        .sel      ({sel1_sen_n, sel0_sdata}),
        .mode     (cfg_mode),
        .preset   (cfg_preset)
    );

    fofs_serial_step #(.IMG_W(IMG_W), .CNT_W(CNT_W)) i_ser (
        .img    (st_q.img),
        .cnt    (st_q.cnt),
        .en     (ser_en),
        .bit_in (sel0_sdata),
        .img_nx (ser_img_nx),
        .cnt_nx (ser_cnt_nx)
    );

    fofs_par_step #(.OFS_W(OFS_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) i_par (
        .img    (st_q.img),
        .cnt    (st_q.cnt),
        .wr     (par_en),
        .data   (par_data),
        .img_nx (par_img_nx),
        .cnt_nx (par_cnt_nx)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.mode = cfg_mode;
            st_d.cnt  = '0;
            st_d.img  = (cfg_mode == MODE_PRESET) ? {SLOTS{cfg_preset}} : '0;
            st_d.done = (cfg_mode == MODE_PRESET);
        end else begin
            case (st_q.mode)
                MODE_SERIAL: begin
                    st_d.img  = ser_img_nx;
                    st_d.cnt  = ser_cnt_nx;
                    st_d.done = (ser_cnt_nx == SER_END);
                end
                MODE_PARALLEL: begin
                    st_d.img  = par_img_nx;
                    st_d.cnt  = par_cnt_nx;
                    st_d.done = (par_cnt_nx == PAR_END);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Image layout, MSB first: Y1, X1, Y2, X2
    assign ofs_y1    = st_q.img[4*OFS_W-1 -: OFS_W];
    assign ofs_x1    = st_q.img[3*OFS_W-1 -: OFS_W];
    assign ofs_y2    = st_q.img[2*OFS_W-1 -: OFS_W];
    assign ofs_x2    = st_q.img[OFS_W-1   -: OFS_W];
    assign prog_done = st_q.done;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |=> prog_done); // R9

    AST_OFS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |=> $stable({ofs_y1, ofs_x1, ofs_y2, ofs_x2})); // R9

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= SER_END); // R6

    AST_SER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_SERIAL && !sel1_sen_n && !prog_done)
        |=> ofs_x2[0] == $past(sel0_sdata)); // R4

    AST_SER_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_SERIAL && sel1_sen_n)
        |=> $stable({ofs_y1, ofs_x1, ofs_y2, ofs_x2})); // R8

    AST_PAR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_PARALLEL && !par_wr)
        |=> $stable({ofs_y1, ofs_x1, ofs_y2, ofs_x2})); // R8

    AST_PRESET_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_PRESET)
        |-> (prog_done && ofs_x1 == ofs_y1 && ofs_x2 == ofs_y1 && ofs_y2 == ofs_y1)); // R2

endmodule

// File: tb/test_flag_offset_loader.sv
`timescale 1ns/1ps
module test_flag_offset_loader;

    localparam int OFS_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             prog_mode = 1'b1;
    logic             sel1_sen_n = 1'b0;
    logic             sel0_sdata = 1'b1;
    logic             par_wr = 1'b0;
    logic [OFS_W-1:0] par_data = '0;
    logic [OFS_W-1:0] ofs_x1, ofs_y1, ofs_x2, ofs_y2;
    logic             prog_done;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // Reference model state: index 0..3 = Y1, X1, Y2, X2
    int m_mode;   // 0 serial, 1 parallel, 2 preset
    int m_cnt;
    int m_ofs[4];
    bit m_done;
    bit m_q[$];

    always #4 clk = ~clk;

    flag_offset_loader i_flag_offset_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_mode  (prog_mode),
        .sel1_sen_n (sel1_sen_n),
        .sel0_sdata (sel0_sdata),
        .par_wr     (par_wr),
        .par_data   (par_data),
        .ofs_x1     (ofs_x1),
        .ofs_y1     (ofs_y1),
        .ofs_x2     (ofs_x2),
        .ofs_y2     (ofs_y2),
        .prog_done  (prog_done)
    );

    function automatic int preset_of(input bit s1, input bit s0);
        case ({s1, s0})
            2'b01:   return 8;
            2'b10:   return 16;
            2'b11:   return 64;
            default: return 0;
        endcase
    endfunction

    task automatic model_edge();
        longint v;
        if (!rst_n) begin
            if (!prog_mode) m_mode = 0;
            else if (!sel1_sen_n && !sel0_sdata) m_mode = 1;
            else m_mode = 2;
            m_cnt = 0;
            m_q.delete();
            for (int i = 0; i < 4; i++)
                m_ofs[i] = (m_mode == 2) ? preset_of(sel1_sen_n, sel0_sdata) : 0;
            m_done = (m_mode == 2);
        end else if (m_mode == 0) begin
            if (!sel1_sen_n && m_cnt < 40) begin
                m_q.push_back(sel0_sdata);
                m_cnt++;
                v = 0;
                foreach (m_q[i]) v = (v << 1) | longint'(m_q[i]);
                m_ofs[0] = int'((v >> 30) & 1023);
                m_ofs[1] = int'((v >> 20) & 1023);
                m_ofs[2] = int'((v >> 10) & 1023);
                m_ofs[3] = int'(v & 1023);
                if (m_cnt == 40) m_done = 1;
            end
        end else if (m_mode == 1) begin
            if (par_wr && m_cnt < 4) begin
                m_ofs[m_cnt] = int'(par_data);
                m_cnt++;
                if (m_cnt == 4) m_done = 1;
            end
        end
    endtask

    task automatic compare(input string req);
        vectors++;
        if (int'(ofs_y1) != m_ofs[0] || int'(ofs_x1) != m_ofs[1] ||
            int'(ofs_y2) != m_ofs[2] || int'(ofs_x2) != m_ofs[3] || prog_done != m_done) begin
            miscompares++;
            $display("FAIL %s: actual y1=%0d x1=%0d y2=%0d x2=%0d done=%0d expected y1=%0d x1=%0d y2=%0d x2=%0d done=%0d",
                     req, ofs_y1, ofs_x1, ofs_y2, ofs_x2, prog_done,
                     m_ofs[0], m_ofs[1], m_ofs[2], m_ofs[3], m_done);
        end
    endtask

    // Drive one cycle at the falling edge, model at the rising edge, compare at the next fall
    task automatic cyc(input bit r, input bit m, input bit s1, input bit s0,
                       input bit w, input logic [OFS_W-1:0] d, input string req);
        rst_n = r; prog_mode = m; sel1_sen_n = s1; sel0_sdata = s0;
        par_wr = w; par_data = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
    endtask

    task automatic chk(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    initial begin
        logic [39:0] stream;
        int sent;
        int k;
        bit b;

        @(negedge clk);

        // Preset 8, then wiggle shared pins and parallel strobe
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 1, 0, '0, "R1");
        for (int i = 0; i < 6; i++) cyc(1, i[0], i[1], ~i[0], 1, 10'h3FF, "R3");
        chk("R2", int'(ofs_x2), 8);
        chk("R8", int'(ofs_y1), 8);

        // Preset 16 and 64
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, 0, '0, "R2");
        cyc(1, 0, 0, 1, 1, 10'h155, "R8");
        chk("R2", int'(ofs_y2), 16);
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 1, 0, '0, "R2");
        cyc(1, 1, 0, 0, 0, '0, "R3");
        chk("R2", int'(ofs_x1), 64);

        // Serial reset, config changed only on last reset edge -> preset 64 wins
        for (int i = 0; i < 2; i++) cyc(0, 0, 0, 0, 0, '0, "R1");
        cyc(0, 1, 1, 1, 0, '0, "R3");
        cyc(1, 0, 0, 1, 0, '0, "R3");
        chk("R3", int'(ofs_y1), 64);
        chk("R3", int'(prog_done), 1);

        // Serial load with gaps and stray parallel writes, then extra bits
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0, '0, "R1");
        chk("R1", int'(prog_done), 0);
        chk("R1", int'(ofs_y1), 0);
        stream = {10'h2A5, 10'h13C, 10'h3F0, 10'h00F};
        sent = 0;
        k = 0;
        while (sent < 48) begin
            if (k % 7 == 3) begin
                cyc(1, 0, 1, k[0], k[1], 10'h2AA, "R4");
            end else begin
                b = (sent < 40) ? stream[39 - sent] : 1'b1;
                cyc(1, 0, 0, b, (k % 5 == 0), 10'h3AA, (sent < 40) ? "R5" : "R6");
                if (sent == 39) chk("R6", int'(prog_done), 1);
                sent++;
            end
            k++;
        end
        chk("R5", int'(ofs_y1), 'h2A5);
        chk("R5", int'(ofs_x1), 'h13C);
        chk("R5", int'(ofs_y2), 'h3F0);
        chk("R5", int'(ofs_x2), 'h00F);

        // Parallel load with gaps and serial enable activity, fifth write ignored
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0, '0, "R1");
        chk("R1", int'(prog_done), 0);
        cyc(1, 1, 0, 1, 1, 10'h101, "R7");
        cyc(1, 1, 0, 0, 0, 10'h3FF, "R8");
        cyc(1, 1, 1, 1, 1, 10'h202, "R7");
        cyc(1, 0, 0, 1, 1, 10'h303, "R7");
        chk("R7", int'(prog_done), 0);
        cyc(1, 1, 0, 0, 0, 10'h111, "R8");
        cyc(1, 1, 1, 0, 1, 10'h044, "R7");
        chk("R7", int'(prog_done), 1);
        cyc(1, 1, 0, 1, 1, 10'h3FF, "R9");
        cyc(1, 1, 0, 1, 1, 10'h3FE, "R9");
        chk("R7", int'(ofs_y1), 'h101);
        chk("R7", int'(ofs_x1), 'h202);
        chk("R7", int'(ofs_y2), 'h303);
        chk("R7", int'(ofs_x2), 'h044);

        // Serial stream cut short by reset mid-way
        for (int i = 0; i < 2; i++) cyc(0, 0, 1, 1, 0, '0, "R1");
        for (int i = 0; i < 12; i++) cyc(1, 0, 0, i[0] ^ i[2], 0, '0, "R5");
        cyc(0, 0, 1, 1, 0, '0, "R1");
        chk("R1", int'(ofs_x2), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL R9 watchdog: actual run still active after 5000 cycles, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule